// File: doc/BRIEF.md
# FPGA Serial Configuration Sequencer

This block loads a configuration image into a target FPGA that boots as a serial slave. After a start pulse it controls the target's active-low reset, its active-low chip select, a serial clock and a serial data line. It also watches the target's done flag, which may change at any time relative to the system clock. The image arrives as a byte stream with a valid/ready handshake and is shifted out MSB first.

The sequence has a fixed shape. First comes a reset pulse with chip select low, then a timed wait so the target can clear its configuration memory. The done flag is checked next, followed by a short burst of dummy clocks with chip select high. The image then goes out as one continuous transfer. After it come a longer dummy burst, a second done check, and a final dummy burst that wakes up the target's user I/O. All waits are parameters in system clock cycles. The serial clock runs at the system clock divided by an even parameter of at least 2.

The block reports `busy`, and then either success or an error with a code. The code tells a failed done check apart from an image stream that ran dry. The outcome is held until the next accepted start.

Top module: `spi_cfg_loader`

## Requirements
- R1: When idle, an accepted start drives `cfg_rst_no` low and `cfg_cs_no` low together for exactly RST_HOLD_CYC cycles, and `busy_o` rises. No serial clock pulse is produced while reset is low.
- R2: After the hold, `cfg_rst_no` goes high while `cfg_cs_no` stays low for exactly CLEAR_WAIT_CYC cycles, with no serial clock pulses.
- R3: If the synchronised done flag is high at the end of the clearing wait, the sequence ends at once. It reports error code 2'b01 (reset-status), with chip select high and no serial clocks sent.
- R4: Otherwise chip select goes high and PRE_BYTES*8 dummy clocks are sent, with data held at 0.
- R5: Chip select then goes low and the image is shifted out MSB first. Data changes while the clock is low and is stable while it is high (clock idles low). Each bit lasts CLK_DIV cycles, with no gap between bytes. `img_last_i` marks the final byte. `img_ready_o` is high only in the cycle where the next byte is taken.
- R6: After the final image bit, chip select goes high and POST_BYTES*8 zero dummy clocks are sent. If the done flag is then low, the sequence ends with error code 2'b01 and sends no further clocks.
- R7: If the done flag is high, ACT_BYTES*8 further zero dummy clocks are sent. The sequence then ends with `success_o` high and error code 2'b00.
- R8: If `img_valid_i` is low in a cycle where an image byte is needed, the sequence stops with error code 2'b10 (underrun). Chip select goes high and no further clocks are sent.
- R9: Success or error is held until the next accepted start, which clears both. A start while `busy_o` is high is ignored.
- R10: After reset the outputs are: reset and chip select high, clock and data low, busy, success, error and ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| img_data_i | input | 8 | Image byte |
| img_valid_i | input | 1 | Image byte valid |
| img_last_i | input | 1 | Marks the final image byte |
| img_ready_o | output | 1 | Image byte taken this cycle |
| cfg_rst_no | output | 1 | Target reset, active low |
| cfg_cs_no | output | 1 | Target chip select, active low |
| cfg_sck_o | output | 1 | Serial clock, idles low |
| cfg_mosi_o | output | 1 | Serial data to target |
| cfg_done_i | input | 1 | Target done flag, asynchronous |
| busy_o | output | 1 | Sequence in progress |
| success_o | output | 1 | Last sequence completed |
| error_o | output | 1 | Last sequence failed |
| err_code_o | output | 2 | 00 none, 01 reset-status, 10 underrun |

## Verification
Two things happen in the same cycle: the last falling clock edge of one image byte, and the decision on the next byte. That decision is either taking the next byte, stopping for the end of the image, or raising underrun. With valid held high, this cycle is judged by the spacing of the target-side rising edges across the whole image, which must be exactly CLK_DIV cycles apart. A stall after two bytes provokes the underrun branch at that same edge; the check there is that exactly 16 bits were received, the error code is 10 and chip select is high. A second start pulse sent in the middle of a run must leave the clock counts and the single outcome unchanged.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RST_HOLD, ST_CLR_WAIT, ST_PRE, ST_IMAGE, ST_POST, ST_ACT
  } seq_st_t;

  typedef enum logic [1:0] {
    ERR_NONE         = 2'b00,
    ERR_RESET_STATUS = 2'b01,
    ERR_UNDERRUN     = 2'b10
  } err_t;
endpackage

// File: rtl/spi_cfg_timer.sv
module spi_cfg_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [7:0] byte_i,
  output logic       take_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF - 1);

  logic             active_q, sck_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       sr_q;
  logic             edge_w, byte_end_w;

  assign edge_w     = active_q && (div_q == DIV_END);
  assign byte_end_w = edge_w && sck_q && (bit_q == 3'd7);
  // next byte handed over on the falling edge that ends the current one
  assign take_o     = !active_q || byte_end_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sr_q     <= '0;
    end else if (ld_i && take_o) begin
      active_q <= 1'b1;
      sck_q    <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sr_q     <= byte_i;
    end else if (byte_end_w) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sr_q     <= '0;
    end else if (active_q) begin
      if (edge_w) begin
        div_q <= '0;
        sck_q <= !sck_q;
        if (sck_q) begin
          bit_q <= bit_q + 3'd1;
          sr_q  <= {sr_q[6:0], 1'b0};
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sr_q[7];
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader
  import spi_cfg_pkg::*;
#(
  parameter int unsigned CLK_DIV        = 4,
  parameter int unsigned RST_HOLD_CYC   = 50,
  parameter int unsigned CLEAR_WAIT_CYC = 300000,
  parameter int unsigned PRE_BYTES      = 1,
  parameter int unsigned POST_BYTES     = 13,
  parameter int unsigned ACT_BYTES      = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] img_data_i,
  input  logic       img_valid_i,
  input  logic       img_last_i,
  output logic       img_ready_o,
  output logic       cfg_rst_no,
  output logic       cfg_cs_no,
  output logic       cfg_sck_o,
  output logic       cfg_mosi_o,
  input  logic       cfg_done_i,
  output logic       busy_o,
  output logic       success_o,
  output logic       error_o,
  output logic [1:0] err_code_o
);
  localparam int unsigned MAX_CYC = (RST_HOLD_CYC > CLEAR_WAIT_CYC) ? RST_HOLD_CYC : CLEAR_WAIT_CYC;
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);
  localparam int unsigned MAX_PA  = (PRE_BYTES > POST_BYTES) ? PRE_BYTES : POST_BYTES;
  localparam int unsigned MAX_B   = (MAX_PA > ACT_BYTES) ? MAX_PA : ACT_BYTES;
  localparam int unsigned DW      = $clog2(MAX_B + 1);

  seq_st_t       state_q, state_d;
  err_t          err_q, err_d;
  logic          succ_q, fail_q;
  logic          tmr_ld, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic [DW-1:0] dcnt_q, dcnt_val;
  logic          dcnt_ld, dcnt_dec;
  logic          sh_ld, sh_take;
  logic [7:0]    sh_byte;
  logic          last_q, last_set;
  logic          set_ok, set_err, start_acc;
  logic          done_m, done_s;
  logic          rst_n_q, cs_n_q;

  assign start_acc = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_m <= 1'b0;
      done_s <= 1'b0;
    end else begin
      done_m <= cfg_done_i;
      done_s <= done_m;
    end
  end

  spi_cfg_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  spi_cfg_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (sh_ld),
    .byte_i (sh_byte),
    .take_o (sh_take),
    .sck_o  (cfg_sck_o),
    .mosi_o (cfg_mosi_o)
  );

  always_comb begin
    state_d     = state_q;
    err_d       = ERR_NONE;
    tmr_ld      = 1'b0;
    tmr_val     = '0;
    dcnt_ld     = 1'b0;
    dcnt_val    = '0;
    dcnt_dec    = 1'b0;
    sh_ld       = 1'b0;
    sh_byte     = 8'h00;
    last_set    = 1'b0;
    set_ok      = 1'b0;
    set_err     = 1'b0;
    img_ready_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RST_HOLD;
        tmr_ld  = 1'b1;
        tmr_val = TW'(RST_HOLD_CYC - 1);
      end
      ST_RST_HOLD: if (tmr_zero) begin
        state_d = ST_CLR_WAIT;
        tmr_ld  = 1'b1;
        tmr_val = TW'(CLEAR_WAIT_CYC - 1);
      end
      ST_CLR_WAIT: if (tmr_zero) begin
        if (done_s) begin
          state_d = ST_IDLE;
          set_err = 1'b1;
          err_d   = ERR_RESET_STATUS;
        end else begin
          state_d  = ST_PRE;
          dcnt_ld  = 1'b1;
          dcnt_val = DW'(PRE_BYTES);
        end
      end
      ST_PRE: if (sh_take) begin
        if (dcnt_q != '0) begin
          sh_ld    = 1'b1;
          dcnt_dec = 1'b1;
        end else begin
          state_d = ST_IMAGE;
        end
      end
      ST_IMAGE: if (sh_take) begin
        if (last_q) begin
          state_d  = ST_POST;
          dcnt_ld  = 1'b1;
          dcnt_val = DW'(POST_BYTES);
        end else begin
          img_ready_o = 1'b1;
          if (img_valid_i) begin
            sh_ld    = 1'b1;
            sh_byte  = img_data_i;
            last_set = img_last_i;
          end else begin
            state_d = ST_IDLE;
            set_err = 1'b1;
            err_d   = ERR_UNDERRUN;
          end
        end
      end
      ST_POST: if (sh_take) begin
        if (dcnt_q != '0) begin
          sh_ld    = 1'b1;
          dcnt_dec = 1'b1;
        end else if (done_s) begin
          state_d  = ST_ACT;
          dcnt_ld  = 1'b1;
          dcnt_val = DW'(ACT_BYTES);
        end else begin
          state_d = ST_IDLE;
          set_err = 1'b1;
          err_d   = ERR_RESET_STATUS;
        end
      end
      ST_ACT: if (sh_take) begin
        if (dcnt_q != '0) begin
          sh_ld    = 1'b1;
          dcnt_dec = 1'b1;
        end else begin
          state_d = ST_IDLE;
          set_ok  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      last_q  <= 1'b0;
      succ_q  <= 1'b0;
      fail_q  <= 1'b0;
      err_q   <= ERR_NONE;
      rst_n_q <= 1'b1;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (dcnt_ld)       dcnt_q <= dcnt_val;
      else if (dcnt_dec) dcnt_q <= dcnt_q - 1'b1;
      if (start_acc)     last_q <= 1'b0;
      else if (last_set) last_q <= 1'b1;
      if (start_acc) begin
        succ_q <= 1'b0;
        fail_q <= 1'b0;
        err_q  <= ERR_NONE;
      end else if (set_ok) begin
        succ_q <= 1'b1;
      end else if (set_err) begin
        fail_q <= 1'b1;
        err_q  <= err_d;
      end
      rst_n_q <= (state_d != ST_RST_HOLD);
      cs_n_q  <= !(state_d inside {ST_RST_HOLD, ST_CLR_WAIT, ST_IMAGE});
    end
  end

  assign cfg_rst_no = rst_n_q;
  assign cfg_cs_no  = cs_n_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign success_o  = succ_q;
  assign error_o    = fail_q;
  assign err_code_o = err_q;
endmodule

// File: rtl/spi_cfg_loader_chk.sv
module spi_cfg_loader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       img_ready_o,
  input logic       cfg_rst_no,
  input logic       cfg_cs_no,
  input logic       cfg_sck_o,
  input logic       cfg_mosi_o,
  input logic       busy_o,
  input logic       success_o,
  input logic       error_o,
  input logic [1:0] err_code_o
);
  AST_CS_LOW_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rst_no |-> (!cfg_cs_no && !cfg_sck_o)); // R1

  AST_MOSI_STABLE_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sck_o && $past(cfg_sck_o)) |-> $stable(cfg_mosi_o)); // R5

  AST_READY_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_ready_o |-> (!cfg_cs_no && cfg_rst_no && busy_o)); // R5

  AST_IDLE_PINS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cfg_sck_o && cfg_cs_no && cfg_rst_no)); // R10

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(success_o && error_o)); // R9

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !success_o && !error_o)); // R9

  AST_ERR_CODE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (err_code_o == 2'b01 || err_code_o == 2'b10)); // R3

  AST_NO_CODE_WITHOUT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !error_o |-> (err_code_o == 2'b00)); // R8
endmodule

bind spi_cfg_loader spi_cfg_loader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .img_ready_o (img_ready_o),
  .cfg_rst_no  (cfg_rst_no),
  .cfg_cs_no   (cfg_cs_no),
  .cfg_sck_o   (cfg_sck_o),
  .cfg_mosi_o  (cfg_mosi_o),
  .busy_o      (busy_o),
  .success_o   (success_o),
  .error_o     (error_o),
  .err_code_o  (err_code_o)
);

// File: tb/tb_spi_cfg_loader.sv
`timescale 1ns/1ps
module tb_spi_cfg_loader;
  localparam int CLK_DIV = 4;
  localparam int RST_HOLD = 5;
  localparam int CLR_WAIT = 20;
  localparam int PRE_B = 1, POST_B = 13, ACT_B = 13;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] img_data;
  logic img_valid, img_last, img_ready;
  logic cfg_rst_n, cfg_cs_n, cfg_sck, cfg_mosi, cfg_done;
  logic busy, success, error;
  logic [1:0] err_code;

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  // stimulus / model control
  logic       mon_clr = 1'b0;
  logic       done_good = 1'b1, done_stuck = 1'b0;
  logic [7:0] src_mem [8];
  int         src_len = 0, stall_at = -1, src_idx = 0;

  // observations
  int cyc = 0, rst_low_cyc = 0, cs_hi_in_rst = 0, wait_cyc = 0;
  int pre_rises = 0, post_rises = 0, rx_bits = 0, first_rise = -1, last_rise = -1;
  int dummy_ones = 0;
  logic [7:0] rx_sr = 8'h00;
  logic [7:0] rx_mem [8];
  logic sck_p = 1'b0, cs_p = 1'b1, done_q = 1'b0;

  assign img_valid = (src_idx < src_len) && (src_idx != stall_at);
  assign img_data  = src_mem[src_idx[2:0]];
  assign img_last  = (src_idx == src_len - 1);
  assign cfg_done  = done_stuck ? 1'b1 : done_q;

  spi_cfg_loader #(
    .CLK_DIV(CLK_DIV), .RST_HOLD_CYC(RST_HOLD), .CLEAR_WAIT_CYC(CLR_WAIT),
    .PRE_BYTES(PRE_B), .POST_BYTES(POST_B), .ACT_BYTES(ACT_B)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .img_data_i(img_data), .img_valid_i(img_valid), .img_last_i(img_last),
    .img_ready_o(img_ready), .cfg_rst_no(cfg_rst_n), .cfg_cs_no(cfg_cs_n),
    .cfg_sck_o(cfg_sck), .cfg_mosi_o(cfg_mosi), .cfg_done_i(cfg_done),
    .busy_o(busy), .success_o(success), .error_o(error), .err_code_o(err_code)
  );

  // target model and monitor, sampled with pre-edge values
  always @(posedge clk) begin
    logic rise;
    logic [7:0] nsr;
    cyc <= cyc + 1;
    rise = cfg_sck && !sck_p;
    sck_p <= cfg_sck;
    cs_p  <= cfg_cs_n;
    if (!cfg_rst_n) done_q <= 1'b0;
    else if (cfg_cs_n && !cs_p && rx_bits > 0) done_q <= done_good;
    if (img_valid && img_ready) src_idx <= src_idx + 1;
    if (mon_clr) begin
      src_idx <= 0; rst_low_cyc <= 0; cs_hi_in_rst <= 0; wait_cyc <= 0;
      pre_rises <= 0; post_rises <= 0; rx_bits <= 0; first_rise <= -1;
      last_rise <= -1; dummy_ones <= 0;
    end else begin
      if (!cfg_rst_n) rst_low_cyc <= rst_low_cyc + 1;
      if (!cfg_rst_n && cfg_cs_n) cs_hi_in_rst <= cs_hi_in_rst + 1;
      if (busy && cfg_rst_n && !cfg_cs_n && rx_bits == 0 && pre_rises == 0)
        wait_cyc <= wait_cyc + 1;
      if (rise && cfg_cs_n) begin
        if (rx_bits == 0) pre_rises <= pre_rises + 1;
        else              post_rises <= post_rises + 1;
        if (cfg_mosi) dummy_ones <= dummy_ones + 1;
      end
      if (rise && !cfg_cs_n) begin
        nsr = {rx_sr[6:0], cfg_mosi};
        rx_sr <= nsr;
        if (rx_bits % 8 == 7) rx_mem[(rx_bits / 8) % 8] <= nsr;
        rx_bits <= rx_bits + 1;
        if (first_rise < 0) first_rise <= cyc;
        last_rise <= cyc;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic prep(input int len, input int stall);
    @(negedge clk);
    src_len = len; stall_at = stall; mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(input int poke_at);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
      if (n == poke_at) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
  endtask

  task automatic t_reset();
    chk("R10 cs", cfg_cs_n, 1); chk("R10 rst", cfg_rst_n, 1);
    chk("R10 sck", cfg_sck, 0); chk("R10 mosi", cfg_mosi, 0);
    chk("R10 busy", busy, 0); chk("R10 ok", success, 0);
    chk("R10 err", error, 0); chk("R10 ready", img_ready, 0);
  endtask

  task automatic t_normal(input int len, input int poke_at);
    prep(len, -1);
    done_good = 1'b1; done_stuck = 1'b0;
    pulse_start();
    chk("R1 busy", busy, 1);
    chk("R9 clear ok", success, 0);
    chk("R9 clear err", error, 0);
    wait_idle(poke_at);
    chk("R1 rst low cycles", rst_low_cyc, RST_HOLD);
    chk("R1 cs with rst", cs_hi_in_rst, 0);
    chk("R2 clear wait", wait_cyc, CLR_WAIT);
    chk("R4 pre clocks", pre_rises, PRE_B * 8);
    chk("R5 image bits", rx_bits, len * 8);
    for (int i = 0; i < len; i++) chk("R5 image byte", rx_mem[i], src_mem[i]);
    chk("R5 continuous", last_rise - first_rise, (len * 8 - 1) * CLK_DIV);
    chk("R6 R7 dummy clocks", post_rises, (POST_B + ACT_B) * 8);
    chk("R6 dummy zero", dummy_ones, 0);
    chk("R7 success", success, 1);
    chk("R7 error", error, 0);
    chk("R7 code", err_code, 0);
    chk("R9 single run", busy, 0);
  endtask

  task automatic t_stuck_done();
    prep(4, -1);
    done_stuck = 1'b1;
    pulse_start();
    wait_idle(-1);
    chk("R3 code", err_code, 1); chk("R3 error", error, 1);
    chk("R3 wait", wait_cyc, CLR_WAIT);
    chk("R3 no clocks", pre_rises + post_rises + rx_bits, 0);
    chk("R3 cs high", cfg_cs_n, 1);
    done_stuck = 1'b0;
  endtask

  task automatic t_no_done();
    prep(2, -1);
    done_good = 1'b0;
    pulse_start();
    wait_idle(-1);
    chk("R6 code", err_code, 1); chk("R6 error", error, 1);
    chk("R6 ok", success, 0);
    chk("R6 post only", post_rises, POST_B * 8);
    chk("R6 bits", rx_bits, 16);
    done_good = 1'b1;
  endtask

  task automatic t_underrun();
    prep(4, 2);
    pulse_start();
    wait_idle(-1);
    chk("R8 code", err_code, 2); chk("R8 error", error, 1);
    chk("R8 bits", rx_bits, 16);
    chk("R8 cs high", cfg_cs_n, 1);
    chk("R8 no dummy", post_rises, 0);
    repeat (20) @(negedge clk);
    chk("R9 held", error, 1);
  endtask

  initial begin
    src_mem[0] = 8'hA5; src_mem[1] = 8'h3C; src_mem[2] = 8'h81; src_mem[3] = 8'hF0;
    src_mem[4] = 8'h01; src_mem[5] = 8'h7E; src_mem[6] = 8'h00; src_mem[7] = 8'hC3;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal(4, -1);
    t_stuck_done();
    t_underrun();
    t_normal(1, -1);
    t_no_done();
    t_normal(8, 150);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule